// File: doc/BRIEF.md
# Issue Scoreboard for Mixed-Latency Execution Units

This block sits beside the decode stage of an in-order pipeline whose execution side has four units of different depth: an integer ALU, a floating-point adder, a multiplier shared by integer and floating-point work, and a divider shared the same way. Each cycle it looks at the instruction waiting in decode: its unit class, its destination register, and up to two source registers, each tagged as integer or floating-point. It raises a stall if sending the instruction on would cause trouble. It then lets the instruction go in the first cycle in which every conflict is gone.

Four kinds of conflict are found at issue time. The first is a busy unit; the divider is not pipelined. The second is a clash on the single register-file write port. The third is a source operand whose producer has not yet reached its forwarding point. The fourth is a destination that an older, slower instruction would overwrite after this one. When an instruction issues, its unit occupancy, its write-port slot and its result timing are recorded. Operations already in flight keep counting down whether decode is stalled or not.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: After reset nothing is in flight, so the first valid instruction of any class issues in its first cycle.
- R2: `id_issue` is high exactly when `id_valid` is high and `id_stall` is low. With `id_valid` low, `id_stall` and all four cause flags are low.
- R3: Unit codes on `id_unit` are ALU=0, FP add=1, multiply=2 and divide=3. Their latency / initiation-interval pairs are 0/1, 1/1, 4/1 and 18/19. An instruction of latency L issued in cycle t writes the register file in cycle t+L+1, and its result may be consumed by an instruction issuing in cycle t+L+1.
- R4: A unit issued in cycle t accepts no new instruction before cycle t+II. A second divide presented just after a first one stalls for exactly 18 cycles (`hz_unit`). Pipelined units accept back-to-back work.
- R5: An instruction with `id_wr_en` high stalls (`hz_port`) if an instruction already issued will write the register file in the same cycle that this one would.
- R6: An instruction stalls (`hz_raw`) while an enabled source register has a producer in flight whose result is not yet available, per R3.
- R7: An instruction with a destination stalls (`hz_waw`) while an older write to that same register lands in a cycle no earlier than its own write cycle. A later write that lands strictly after the older one does not stall.
- R8: Integer register 0 never causes a hazard. Writes to it create no pending result and no ordering check, and reads from it never wait. Writes to it still take a write-port slot.
- R9: Integer and floating-point registers with the same number are tracked independently.
- R10: When several conflicts hold at once, a single stall is raised, and the instruction issues in the first cycle in which all of them have cleared.
- R11: In-flight operations advance every cycle regardless of a stall in decode. An instruction that depends only on work issued before a long stall issues without extra delay once it reaches decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | An instruction is waiting in decode |
| id_unit | input | 2 | Unit class: 0 ALU, 1 FP add, 2 multiply, 3 divide |
| id_wr_en | input | 1 | Instruction writes a register |
| id_wr_fp | input | 1 | Destination is in the floating-point file |
| id_wr_reg | input | REG_AW | Destination register number |
| id_ra_en | input | 1 | First source is used |
| id_ra_fp | input | 1 | First source is floating-point |
| id_ra_reg | input | REG_AW | First source register number |
| id_rb_en | input | 1 | Second source is used |
| id_rb_fp | input | 1 | Second source is floating-point |
| id_rb_reg | input | REG_AW | Second source register number |
| id_stall | output | 1 | Hold the instruction in decode |
| id_issue | output | 1 | Instruction leaves decode at this edge |
| hz_unit | output | 1 | Target unit is still occupied |
| hz_port | output | 1 | Write-port slot already taken |
| hz_raw | output | 1 | A source result is not yet available |
| hz_waw | output | 1 | An older write to the destination would land last |

## Verification
Dependent pairs are run through each unit: ALU-to-ALU, FP add, multiply and divide producers feeding a consumer. The measured stall counts (0, 1, 4 and 18) separate the latency of each unit. Same-destination pairs are run in both orders, slow-then-fast and fast-then-slow, so that an ordering check that fires in both directions is told apart from one that only guards out-of-order completion. A divide followed after a chosen gap by an ALU op pins the write-port slot to the exact cycle. Pairs that differ only in register file, or that use integer register 0, show that the tag and the exemption are honoured. Overlapping stalls show whether unrelated in-flight work keeps draining.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  typedef enum logic [1:0] {
    FU_ALU  = 2'd0,
    FU_FADD = 2'd1,
    FU_MUL  = 2'd2,
    FU_DIV  = 2'd3
  } fu_e;

  localparam int NUM_FU = 4;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // a register takes part in hazard tracking unless it is integer zero
  function automatic logic is_tracked(input logic fp, input logic [7:0] num);
    return fp || (num != 8'd0);
  endfunction
endpackage

// File: rtl/sb_unit_busy.sv
`timescale 1ns/1ps
module sb_unit_busy #(
  parameter int II = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic free
);
  localparam int CW = (II > 1) ? $clog2(II) : 1;

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= CW'(II - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign free = (left_q == '0);
endmodule

// File: rtl/sb_wport_timeline.sv
`timescale 1ns/1ps
module sb_wport_timeline #(
  parameter int DEPTH = 19,
  parameter int LW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] q_lat,
  input  logic          book,
  output logic          busy_at
);
  // slot_q[k] set: the write port is taken k+1 cycles from now
  logic [DEPTH-1:0] slot_q, slot_d;

  assign busy_at = slot_q[q_lat];

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      slot_d[k] = ((k + 1 < DEPTH) ? slot_q[(k + 1) % DEPTH] : 1'b0)
                | (book && (q_lat != '0) && ((int'(q_lat) - 1) == k));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end
endmodule

// File: rtl/sb_reg_timer.sv
`timescale 1ns/1ps
module sb_reg_timer #(
  parameter int TAGW = 6,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [TAGW-1:0] set_tag,
  input  logic [LW-1:0]   set_val,
  input  logic [TAGW-1:0] qa_tag,
  input  logic [TAGW-1:0] qb_tag,
  input  logic [TAGW-1:0] qd_tag,
  output logic [LW-1:0]   rem_a,
  output logic [LW-1:0]   rem_b,
  output logic [LW-1:0]   rem_d
);
  localparam int NENT = 1 << TAGW;

  // cycles until each register's pending result can be consumed
  logic [LW-1:0] rem_q [NENT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++) begin
      if (!rst_n) begin
        rem_q[i] <= '0;
      end else if (set_en && (set_tag == TAGW'(i))) begin
        rem_q[i] <= set_val;
      end else if (rem_q[i] != '0) begin
        rem_q[i] <= rem_q[i] - 1'b1;
      end
    end
  end

  assign rem_a = rem_q[qa_tag];
  assign rem_b = rem_q[qb_tag];
  assign rem_d = rem_q[qd_tag];
endmodule

// File: rtl/sb_issue_scoreboard.sv
`timescale 1ns/1ps
module sb_issue_scoreboard
  import sb_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int LAT_ALU = 0,
  parameter int LAT_FADD = 1,
  parameter int LAT_MUL = 4,
  parameter int LAT_DIV = 18,
  parameter int II_ALU  = 1,
  parameter int II_FADD = 1,
  parameter int II_MUL  = 1,
  parameter int II_DIV  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [1:0]        id_unit,
  input  logic              id_wr_en,
  input  logic              id_wr_fp,
  input  logic [REG_AW-1:0] id_wr_reg,
  input  logic              id_ra_en,
  input  logic              id_ra_fp,
  input  logic [REG_AW-1:0] id_ra_reg,
  input  logic              id_rb_en,
  input  logic              id_rb_fp,
  input  logic [REG_AW-1:0] id_rb_reg,
  output logic              id_stall,
  output logic              id_issue,
  output logic              hz_unit,
  output logic              hz_port,
  output logic              hz_raw,
  output logic              hz_waw
);
  localparam int MAX_LAT = max_of4(LAT_ALU, LAT_FADD, LAT_MUL, LAT_DIV);
  localparam int LW      = $clog2(MAX_LAT + 2);
  localparam int TAGW    = REG_AW + 1;

  function automatic logic [LW-1:0] lat_of(input logic [1:0] u);
    case (fu_e'(u))
      FU_ALU:  return LW'(LAT_ALU);
      FU_FADD: return LW'(LAT_FADD);
      FU_MUL:  return LW'(LAT_MUL);
      default: return LW'(LAT_DIV);
    endcase
  endfunction

  function automatic logic trk(input logic fp, input logic [REG_AW-1:0] num);
    return is_tracked(fp, 8'(num));
  endfunction

  // named internal events
  logic [LW-1:0]     op_lat;
  logic [TAGW-1:0]   tag_d, tag_a, tag_b;
  logic [LW-1:0]     rem_a, rem_b, rem_d;
  logic              dst_tracked;
  logic              src_a_wait, src_b_wait;
  logic              slot_taken;
  logic [NUM_FU-1:0] fu_free, fu_start;
  logic              rec_en, book_en;

  assign op_lat      = lat_of(id_unit);
  assign tag_d       = {id_wr_fp, id_wr_reg};
  assign tag_a       = {id_ra_fp, id_ra_reg};
  assign tag_b       = {id_rb_fp, id_rb_reg};
  assign dst_tracked = id_wr_en && trk(id_wr_fp, id_wr_reg);
  assign src_a_wait  = id_ra_en && trk(id_ra_fp, id_ra_reg) && (rem_a != '0);
  assign src_b_wait  = id_rb_en && trk(id_rb_fp, id_rb_reg) && (rem_b != '0);

  assign hz_unit  = id_valid && !fu_free[id_unit];
  assign hz_port  = id_valid && id_wr_en && slot_taken;
  assign hz_raw   = id_valid && (src_a_wait || src_b_wait);
  assign hz_waw   = id_valid && dst_tracked && (rem_d > op_lat);
  assign id_stall = hz_unit || hz_port || hz_raw || hz_waw;
  assign id_issue = id_valid && !id_stall;

  assign rec_en  = id_issue && dst_tracked;
  assign book_en = id_issue && id_wr_en;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    localparam int IIG = (g == 0) ? II_ALU : (g == 1) ? II_FADD :
                         (g == 2) ? II_MUL : II_DIV;
    assign fu_start[g] = id_issue && (id_unit == 2'(g));
    sb_unit_busy #(.II(IIG)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fu_start[g]),
      .free  (fu_free[g])
    );
  end

  sb_wport_timeline #(.DEPTH(MAX_LAT + 1), .LW(LW)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_lat   (op_lat),
    .book    (book_en),
    .busy_at (slot_taken)
  );

  sb_reg_timer #(.TAGW(TAGW), .LW(LW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (rec_en),
    .set_tag (tag_d),
    .set_val (op_lat),
    .qa_tag  (tag_a),
    .qb_tag  (tag_b),
    .qd_tag  (tag_d),
    .rem_a   (rem_a),
    .rem_b   (rem_b),
    .rem_d   (rem_d)
  );
endmodule

// File: rtl/sb_issue_checker.sv
`timescale 1ns/1ps
module sb_issue_checker #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic [1:0]        id_unit,
  input logic              id_wr_en,
  input logic              id_wr_fp,
  input logic [REG_AW-1:0] id_wr_reg,
  input logic              id_ra_en,
  input logic              id_ra_fp,
  input logic [REG_AW-1:0] id_ra_reg,
  input logic              id_stall,
  input logic              id_issue,
  input logic              hz_unit,
  input logic              hz_port,
  input logic              hz_raw,
  input logic              hz_waw,
  input logic [3:0]        fu_free
);
  a_r2_issue_excludes_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_issue && id_stall));

  a_r2_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !(id_stall || hz_unit || hz_port || hz_raw || hz_waw));

  a_r4_divide_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    $past(id_issue && id_unit == 2'd3) && id_valid && id_unit == 2'd3 |-> hz_unit);

  a_r4_divider_claimed_by_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fu_free[3]) |-> $past(id_issue && id_unit == 2'd3));

  a_r5_fadd_then_alu_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(id_issue && id_wr_en && id_unit == 2'd1) && id_valid && id_wr_en
      && id_unit == 2'd0 |-> hz_port);

  a_r6_fp_multiply_consumer: assert property (@(posedge clk) disable iff (!rst_n)
    $past(id_issue && id_wr_en && id_wr_fp && id_unit == 2'd2) && id_valid
      && id_ra_en && id_ra_fp && id_ra_reg == $past(id_wr_reg) |-> hz_raw);

  a_r7_short_after_multiply: assert property (@(posedge clk) disable iff (!rst_n)
    $past(id_issue && id_wr_en && id_wr_fp && id_unit == 2'd2) && id_valid
      && id_wr_en && id_wr_fp && id_wr_reg == $past(id_wr_reg)
      && !id_unit[1] |-> hz_waw);
endmodule

bind sb_issue_scoreboard sb_issue_checker #(.REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .id_valid  (id_valid),
  .id_unit   (id_unit),
  .id_wr_en  (id_wr_en),
  .id_wr_fp  (id_wr_fp),
  .id_wr_reg (id_wr_reg),
  .id_ra_en  (id_ra_en),
  .id_ra_fp  (id_ra_fp),
  .id_ra_reg (id_ra_reg),
  .id_stall  (id_stall),
  .id_issue  (id_issue),
  .hz_unit   (hz_unit),
  .hz_port   (hz_port),
  .hz_raw    (hz_raw),
  .hz_waw    (hz_waw),
  .fu_free   (fu_free)
);

// File: tb/sim_sb_issue_scoreboard.sv
`timescale 1ns/1ps
module sim_sb_issue_scoreboard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0;
  logic [1:0] u = 2'd0;
  logic we = 1'b0, wf = 1'b0, ae = 1'b0, af = 1'b0, be = 1'b0, bf = 1'b0;
  logic [4:0] wr = 5'd0, ar = 5'd0, br = 5'd0;
  logic stall, issue, h_unit, h_port, h_raw, h_waw;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state (absolute cycle numbers)
  int now = 0;
  int rdy [64];
  int ufree [4];
  bit wused [int];
  int lat_t [4] = '{0, 1, 4, 18};
  int ii_t  [4] = '{1, 1, 1, 19};

  always #2 clk = ~clk;

  sb_issue_scoreboard u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(v), .id_unit(u),
    .id_wr_en(we), .id_wr_fp(wf), .id_wr_reg(wr),
    .id_ra_en(ae), .id_ra_fp(af), .id_ra_reg(ar),
    .id_rb_en(be), .id_rb_fp(bf), .id_rb_reg(br),
    .id_stall(stall), .id_issue(issue),
    .hz_unit(h_unit), .hz_port(h_port), .hz_raw(h_raw), .hz_waw(h_waw)
  );

  function automatic bit trk(input logic fp, input logic [4:0] r);
    return fp || (r != 5'd0);
  endfunction

  task automatic cmp(input string req, input logic got, input logic exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %b expected %b", req, now, got, exp);
    end
  endtask

  // one clock: called at posedge+1 with inputs set; leaves at next posedge+1
  task automatic step(output bit issued);
    bit e_unit, e_port, e_raw, e_waw, e_stall, e_issue;
    int l;
    #1;
    l = lat_t[u];
    e_unit = v && (ufree[u] > now);
    e_port = v && we && wused.exists(now + l + 1);
    e_raw  = v && ((ae && trk(af, ar) && rdy[int'({af, ar})] > now) ||
                   (be && trk(bf, br) && rdy[int'({bf, br})] > now));
    e_waw  = v && we && trk(wf, wr) && (rdy[int'({wf, wr})] > now + l);
    e_stall = e_unit || e_port || e_raw || e_waw;
    e_issue = v && !e_stall;
    vecs++;
    cmp("R4 unit flag", h_unit, e_unit);
    cmp("R5 port flag", h_port, e_port);
    cmp("R6 raw flag", h_raw, e_raw);
    cmp("R7 waw flag", h_waw, e_waw);
    cmp("R10 stall", stall, e_stall);
    cmp("R2 issue", issue, e_issue);
    if (e_issue) begin
      ufree[u] = now + ii_t[u];
      if (we) wused[now + l + 1] = 1'b1;
      if (we && trk(wf, wr)) rdy[int'({wf, wr})] = now + l + 1;
    end
    issued = e_issue;
    now++;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    bit s;
    v = 1'b0;
    for (int i = 0; i < n; i++) step(s);
  endtask

  task automatic op(input logic [1:0] unit,
                    input logic w_en, input logic w_fp, input logic [4:0] w_r,
                    input logic a_en, input logic a_fp, input logic [4:0] a_r,
                    input logic b_en, input logic b_fp, input logic [4:0] b_r,
                    output int stalls);
    bit s;
    v = 1'b1; u = unit;
    we = w_en; wf = w_fp; wr = w_r;
    ae = a_en; af = a_fp; ar = a_r;
    be = b_en; bf = b_fp; br = b_r;
    stalls = 0;
    for (int i = 0; i < 200; i++) begin
      step(s);
      if (s) break;
      stalls++;
    end
    v = 1'b0;
  endtask

  task automatic expect_n(input string req, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: stall cycles got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 64; i++) rdy[i] = 0;
    for (int i = 0; i < 4; i++) ufree[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: first ALU op after reset goes at once
    op(2'd0, 1, 0, 5'd1, 1, 0, 5'd2, 1, 0, 5'd3, n); expect_n("R1 first issue", n, 0);
    // R3: ALU result forwards to the next ALU op
    op(2'd0, 1, 0, 5'd4, 1, 0, 5'd1, 0, 0, 5'd0, n); expect_n("R3 alu chain", n, 0);
    idle(25);
    // R3/R6: FP add producer, one wait cycle
    op(2'd1, 1, 1, 5'd1, 1, 1, 5'd2, 0, 0, 5'd0, n);
    op(2'd1, 1, 1, 5'd3, 1, 1, 5'd1, 0, 0, 5'd0, n); expect_n("R6 fadd consumer", n, 1);
    idle(25);
    // R6: multiply producer, four wait cycles
    op(2'd2, 1, 1, 5'd2, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd1, 1, 1, 5'd5, 0, 0, 5'd0, 1, 1, 5'd2, n); expect_n("R6 mul consumer", n, 4);
    idle(25);
    // R7: slow then fast to same register
    op(2'd2, 1, 1, 5'd4, 1, 1, 5'd6, 1, 1, 5'd6, n);
    op(2'd1, 1, 1, 5'd4, 1, 1, 5'd8, 1, 1, 5'd8, n); expect_n("R7 slow then fast", n, 3);
    idle(25);
    // R7: fast then slow to same register, no stall
    op(2'd1, 1, 1, 5'd4, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd2, 1, 1, 5'd4, 0, 0, 5'd0, 0, 0, 5'd0, n); expect_n("R7 fast then slow", n, 0);
    idle(25);
    // R5: FP add then ALU, same write cycle
    op(2'd1, 1, 1, 5'd1, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd0, 1, 0, 5'd1, 1, 0, 5'd2, 0, 0, 5'd0, n); expect_n("R5 port clash", n, 1);
    idle(25);
    // R4: two divides back to back
    op(2'd3, 1, 1, 5'd10, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd3, 1, 1, 5'd11, 0, 0, 5'd0, 0, 0, 5'd0, n); expect_n("R4 divider busy", n, 18);
    idle(40);
    // R5: ALU aimed at the divide's write cycle
    op(2'd3, 1, 1, 5'd12, 0, 0, 5'd0, 0, 0, 5'd0, n);
    idle(17);
    op(2'd0, 1, 0, 5'd9, 0, 0, 5'd0, 0, 0, 5'd0, n); expect_n("R5 divide slot", n, 1);
    idle(40);
    // R11: multiply result drains during a divide stall
    op(2'd2, 1, 1, 5'd5, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd3, 1, 1, 5'd6, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd3, 1, 1, 5'd7, 0, 0, 5'd0, 0, 0, 5'd0, n); expect_n("R11 second divide", n, 18);
    op(2'd1, 1, 1, 5'd8, 1, 1, 5'd5, 0, 0, 5'd0, n); expect_n("R11 drained producer", n, 0);
    idle(40);
    // R8: integer register zero
    op(2'd2, 1, 0, 5'd0, 1, 0, 5'd1, 1, 0, 5'd1, n);
    op(2'd0, 1, 0, 5'd2, 1, 0, 5'd0, 0, 0, 5'd0, n); expect_n("R8 read r0", n, 0);
    op(2'd0, 1, 0, 5'd0, 1, 0, 5'd3, 0, 0, 5'd0, n); expect_n("R8 write r0", n, 0);
    idle(25);
    // R9: same number, other file
    op(2'd2, 1, 1, 5'd7, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd0, 1, 0, 5'd7, 1, 0, 5'd7, 0, 0, 5'd0, n); expect_n("R9 split files", n, 0);
    idle(25);
    // R10: unit and raw conflicts together
    op(2'd3, 1, 1, 5'd3, 0, 0, 5'd0, 0, 0, 5'd0, n);
    op(2'd3, 1, 1, 5'd13, 1, 1, 5'd3, 0, 0, 5'd0, n); expect_n("R10 combined", n, 18);
    idle(30);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule